// File: doc/BRIEF.md
# Deferred PLL Frequency Change Sequencer

This block is a small clock-management unit behind a byte-wide register port. Software writes a new PLL frequency code into a staging register, and that write alone changes nothing. The code becomes active only when the chip goes through a sleep/wake cycle. The cycle starts on a `sleep_req` pulse. The block then waits a programmable settle time, commits the staged code to the active output, raises a sticky frequency-change event that can wake the core, and returns to normal operation. The PLL is modelled only by its active frequency code.

The commit can be blocked. If the host bus pad is enabled and the chip-select input (`cs_n`) is low at the commit point, the change fails. In that case the active code is kept, no event is raised, and a sticky fail flag is set. Software avoids this by clearing the pad enable before it starts the change. The active code can be read back separately, so software can skip a change that is not needed.

The block also holds clock-gating registers, in which a 1 stops a peripheral clock. The auto-gating enable register implements only its defined bits.

The sequencer has four states:
- RUN: normal operation.
- SLEEP: the settle counter runs down.
- COMMIT: the block tests the chip-select block and applies or rejects the code.
- WAKE: a one-cycle wake pulse.

The transitions are:
- RUN→SLEEP on `sleep_req`.
- SLEEP→SLEEP while the counter is non-zero.
- SLEEP→COMMIT when the counter reaches zero.
- COMMIT→WAKE always.
- WAKE→RUN always.

Top module: `clkpm_pll_seq`

## Requirements
- R1: After reset the registers read as follows. Staged and active codes are 0x07, gating register A is 0x00, gating register B is 0x40, auto-gating is 0x74, status is 0x00, pad enable is 1 and settle holds its reset parameter. `pll_irq`, `in_sleep` and `wake` are all low.
- R2: The frequency code is the low 4 bits of address 3. Only the codes 0x1, 0x3, 0x7 and 0x9 are legal. A write of any other code is ignored, and the staged value stays as it was.
- R3: A write to address 3 never changes `pll_code` or the active code at address 4. The active code changes only during a sleep/wake sequence.
- R4: `in_sleep` falls exactly settle+4 rising edges after the edge that samples `sleep_req` in RUN. A committed code appears on `pll_code` at edge settle+3. Settle is the value at address 7.
- R5: A successful commit sets the event flag (status bit 0, output `pll_irq`) on the same edge as the code change. `wake` is high for exactly one cycle per sequence.
- R6: The event flag stays set until software writes 1 to status bit 0. Writing 0 has no effect. A further commit while the flag is set leaves `pll_irq` high with no falling edge.
- R7: If pad enable (address 6 bit 0) is 1 and `cs_n` is low at COMMIT, the code is not applied, no event is raised, and fail flag status bit 2 is set. Bit 2 is cleared by writing 1 to it. With pad enable 0, the commit ignores `cs_n`.
- R8: Gating register A (address 0) is a plain 8-bit register driven on `gate_a`, where 1 means the clock is stopped.
- R9: Gating register B (address 1) always reads with bit 6 at 1, on both the register and `gate_b`, whatever value is written.
- R10: In the auto-gating register (address 2), only bits 6, 5, 4 and 2 are writable. All other bits read 0.
- R11: The settle register (address 7) reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| sleep_req | input | 1 | Start a sleep/wake commit sequence |
| cs_n | input | 1 | Host bus chip-select, low = active |
| pll_code | output | 4 | Active PLL frequency code |
| pll_irq | output | 1 | Frequency-change event flag (rising-edge interrupt source) |
| in_sleep | output | 1 | Sequencer is outside RUN |
| wake | output | 1 | One-cycle wake pulse |
| gate_a | output | 8 | Clock gate controls, group A |
| gate_b | output | 8 | Clock gate controls, group B |
| auto_gate | output | 8 | Auto-gating enables |

## Verification
The bench builds the block with a 4-bit settle counter and a reset settle value of 2. This brings the counter's full range within reach: a settle of 0 and the maximum of 15 each run in a few cycles. At each of these extremes, and at the reset value, the bench checks the exact edge at which the code commits and the edge at which `in_sleep` falls. The commit tests cover the chip-select block with pad enable on and off, and a second commit while the event flag is still set.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int ADDR_W = 3;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_18M4 = 4'h1;
    localparam logic [CODE_W-1:0] CODE_32M3 = 4'h3;
    localparam logic [CODE_W-1:0] CODE_64M5 = 4'h7;
    localparam logic [CODE_W-1:0] CODE_48M0 = 4'h9;

    typedef enum logic [ADDR_W-1:0] {
        RA_GATE_A = 3'd0,
        RA_GATE_B = 3'd1,
        RA_AUTO   = 3'd2,
        RA_STAGE  = 3'd3,
        RA_ACTIVE = 3'd4,
        RA_STATUS = 3'd5,
        RA_CTRL   = 3'd6,
        RA_SETTLE = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_WAKE   = 2'd3
    } seq_state_e;

    // status bit positions
    localparam int STS_EVT  = 0;
    localparam int STS_BUSY = 1;
    localparam int STS_FAIL = 2;

    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        return (c == CODE_18M4) || (c == CODE_32M3) ||
               (c == CODE_64M5) || (c == CODE_48M0);
    endfunction

endpackage

// File: rtl/clkpm_seq_fsm.sv
module clkpm_seq_fsm
    import clkpm_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                cs_n,
    input  logic                pad_en,
    input  logic [SETTLE_W-1:0] settle_val,
    output logic                commit_ok,
    output logic                commit_fail,
    output logic                in_sleep,
    output logic                wake
);

    seq_state_e          state_q, state_d;
    logic [SETTLE_W-1:0] cnt_q;
    logic                blocked;

    assign blocked = pad_en && !cs_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (sleep_req) state_d = ST_SLEEP;
            ST_SLEEP:  if (cnt_q == '0) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_WAKE;
            ST_WAKE:   state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_RUN && sleep_req) begin
            cnt_q <= settle_val;
        end else if (state_q == ST_SLEEP && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        commit_ok   = 1'b0;
        commit_fail = 1'b0;
        in_sleep    = 1'b1;
        wake        = 1'b0;
        unique case (state_q)
            ST_RUN:    in_sleep = 1'b0;
            ST_SLEEP:  ;
            ST_COMMIT: begin
                commit_ok   = !blocked;
                commit_fail = blocked;
            end
            ST_WAKE:   wake = 1'b1;
            default:   in_sleep = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkpm_regs.sv
module clkpm_regs
    import clkpm_pkg::*;
#(
    parameter int                 SETTLE_W   = 8,
    parameter logic [SETTLE_W-1:0] RST_SETTLE = 4,
    parameter logic [CODE_W-1:0]  RST_CODE   = 4'h7,
    parameter logic [7:0]         AUTO_MASK  = 8'h74,
    parameter int                 PIN_BIT    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic                commit_ok,
    input  logic                commit_fail,
    input  logic                busy,
    output logic [CODE_W-1:0]   active_code,
    output logic                evt_flag,
    output logic                pad_en,
    output logic [SETTLE_W-1:0] settle_val,
    output logic [7:0]          gate_a,
    output logic [7:0]          gate_b,
    output logic [7:0]          auto_gate
);

    localparam logic [7:0] PIN_MASK = 8'(1) << PIN_BIT;

    logic [7:0]          gate_a_q, gate_b_q, auto_q;
    logic [CODE_W-1:0]   stage_q, active_q;
    logic                evt_q, fail_q, pad_q;
    logic [SETTLE_W-1:0] settle_q;
    reg_addr_e           ra;

    assign ra = reg_addr_e'(addr);

    // gating and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_a_q <= '0;
            gate_b_q <= PIN_MASK;
            auto_q   <= AUTO_MASK;
            pad_q    <= 1'b1;
            settle_q <= RST_SETTLE;
        end else if (wr) begin
            unique case (ra)
                RA_GATE_A: gate_a_q <= wdata;
                RA_GATE_B: gate_b_q <= wdata | PIN_MASK;
                RA_AUTO:   auto_q   <= wdata & AUTO_MASK;
                RA_CTRL:   pad_q    <= wdata[0];
                RA_SETTLE: settle_q <= SETTLE_W'(wdata);
                default:   ;
            endcase
        end
    end

    // staged frequency code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= RST_CODE;
        end else if (wr && ra == RA_STAGE && code_legal(wdata[CODE_W-1:0])) begin
            stage_q <= wdata[CODE_W-1:0];
        end
    end

    // active frequency code, loaded only on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= RST_CODE;
        end else if (commit_ok) begin
            active_q <= stage_q;
        end
    end

    // sticky event and fail flags, write-one-to-clear, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (commit_ok) begin
                evt_q <= 1'b1;
            end else if (wr && ra == RA_STATUS && wdata[STS_EVT]) begin
                evt_q <= 1'b0;
            end
            if (commit_fail) begin
                fail_q <= 1'b1;
            end else if (wr && ra == RA_STATUS && wdata[STS_FAIL]) begin
                fail_q <= 1'b0;
            end
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        unique case (ra)
            RA_GATE_A: rdata = gate_a_q;
            RA_GATE_B: rdata = gate_b_q;
            RA_AUTO:   rdata = auto_q;
            RA_STAGE:  rdata = 8'(stage_q);
            RA_ACTIVE: rdata = 8'(active_q);
            RA_STATUS: begin
                rdata[STS_EVT]  = evt_q;
                rdata[STS_BUSY] = busy;
                rdata[STS_FAIL] = fail_q;
            end
            RA_CTRL:   rdata = {7'b0, pad_q};
            RA_SETTLE: rdata = 8'(settle_q);
            default:   rdata = '0;
        endcase
    end

    assign active_code = active_q;
    assign evt_flag    = evt_q;
    assign pad_en      = pad_q;
    assign settle_val  = settle_q;
    assign gate_a      = gate_a_q;
    assign gate_b      = gate_b_q;
    assign auto_gate   = auto_q;

endmodule

// File: rtl/clkpm_pll_seq.sv
module clkpm_pll_seq
    import clkpm_pkg::*;
#(
    parameter int                 SETTLE_W   = 8,
    parameter logic [SETTLE_W-1:0] RST_SETTLE = 4,
    parameter logic [CODE_W-1:0]  RST_CODE   = 4'h7,
    parameter logic [7:0]         AUTO_MASK  = 8'h74,
    parameter int                 PIN_BIT    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sleep_req,
    input  logic              cs_n,
    output logic [CODE_W-1:0] pll_code,
    output logic              pll_irq,
    output logic              in_sleep,
    output logic              wake,
    output logic [7:0]        gate_a,
    output logic [7:0]        gate_b,
    output logic [7:0]        auto_gate
);

    logic                commit_ok, commit_fail, pad_en;
    logic [SETTLE_W-1:0] settle_val;

    clkpm_seq_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .cs_n        (cs_n),
        .pad_en      (pad_en),
        .settle_val  (settle_val),
        .commit_ok   (commit_ok),
        .commit_fail (commit_fail),
        .in_sleep    (in_sleep),
        .wake        (wake)
    );

    clkpm_regs #(
        .SETTLE_W   (SETTLE_W),
        .RST_SETTLE (RST_SETTLE),
        .RST_CODE   (RST_CODE),
        .AUTO_MASK  (AUTO_MASK),
        .PIN_BIT    (PIN_BIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .wr          (reg_wr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .commit_ok   (commit_ok),
        .commit_fail (commit_fail),
        .busy        (in_sleep),
        .active_code (pll_code),
        .evt_flag    (pll_irq),
        .pad_en      (pad_en),
        .settle_val  (settle_val),
        .gate_a      (gate_a),
        .gate_b      (gate_b),
        .auto_gate   (auto_gate)
    );

endmodule

// File: rtl/clkpm_pll_seq_chk.sv
module clkpm_pll_seq_chk #(
    parameter logic [7:0] AUTO_MASK = 8'h74,
    parameter int         PIN_BIT   = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] pll_code,
    input logic       pll_irq,
    input logic       in_sleep,
    input logic       wake,
    input logic       cs_n,
    input logic       pad_en,
    input logic [7:0] gate_b,
    input logic [7:0] auto_gate
);

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_code == 4'h1 || pll_code == 4'h3 || pll_code == 4'h7 || pll_code == 4'h9)); // R2

    AST_CODE_ONLY_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_code != $past(pll_code)) |-> $past(in_sleep)); // R3

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake); // R5

    AST_IRQ_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_irq) |-> wake); // R5

    AST_IRQ_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_irq) |-> !($past(pad_en) && !$past(cs_n))); // R7

    AST_GATE_B_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        gate_b[PIN_BIT]); // R9

    AST_AUTO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_gate & ~AUTO_MASK) == 8'h00); // R10

endmodule

bind clkpm_pll_seq clkpm_pll_seq_chk #(
    .AUTO_MASK (AUTO_MASK),
    .PIN_BIT   (PIN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_code  (pll_code),
    .pll_irq   (pll_irq),
    .in_sleep  (in_sleep),
    .wake      (wake),
    .cs_n      (cs_n),
    .pad_en    (pad_en),
    .gate_b    (gate_b),
    .auto_gate (auto_gate)
);

// File: tb/tb_clkpm_pll_seq.sv
module tb_clkpm_pll_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] pll_code;
    logic       pll_irq, in_sleep, wake;
    logic [7:0] gate_a, gate_b, auto_gate;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    clkpm_pll_seq #(.SETTLE_W(4), .RST_SETTLE(4'd2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sleep_req (sleep_req),
        .cs_n      (cs_n),
        .pll_code  (pll_code),
        .pll_irq   (pll_irq),
        .in_sleep  (in_sleep),
        .wake      (wake),
        .gate_a    (gate_a),
        .gate_b    (gate_b),
        .auto_gate (auto_gate)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_sleep(input string req, input int settle, input bit exp_change,
                             input logic [3:0] exp_code);
        logic [3:0] old;
        int n, change_at, wakes;
        bit irq_fell, prev_irq;
        @(negedge clk);
        old = pll_code; prev_irq = pll_irq;
        change_at = 0; wakes = 0; irq_fell = 0;
        sleep_req = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        sleep_req = 1'b0;
        while (in_sleep && n < 100) begin
            if (pll_code != old && change_at == 0) change_at = n;
            if (wake) wakes++;
            if (prev_irq && !pll_irq) irq_fell = 1;
            prev_irq = pll_irq;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        if (pll_code != old && change_at == 0) change_at = n;
        chk({req, " in_sleep duration"}, n, settle + 4);
        chk({req, " commit edge"}, change_at, exp_change ? settle + 3 : 0);
        chk({req, " pll_code"}, pll_code, exp_code);
        chk({req, " wake pulses"}, wakes, 1);
        chk({req, " irq no falling edge"}, irq_fell, 0);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(3'd3, d); chk("R1 staged", d, 8'h07);
        rd(3'd4, d); chk("R1 active", d, 8'h07);
        rd(3'd0, d); chk("R1 gate_a", d, 8'h00);
        rd(3'd1, d); chk("R1 gate_b", d, 8'h40);
        rd(3'd2, d); chk("R1 auto", d, 8'h74);
        rd(3'd5, d); chk("R1 status", d, 8'h00);
        rd(3'd6, d); chk("R1 pad_en", d, 8'h01);
        rd(3'd7, d); chk("R1 settle", d, 8'h02);
        chk("R1 outputs", {pll_irq, in_sleep, wake}, 0);
    endtask

    task automatic t_gating;
        logic [7:0] d;
        wr(3'd0, 8'hA5); rd(3'd0, d);
        chk("R8 gate_a read", d, 8'hA5); chk("R8 gate_a port", gate_a, 8'hA5);
        wr(3'd1, 8'h00); rd(3'd1, d);
        chk("R9 gate_b pin after 00", d, 8'h40); chk("R9 gate_b port", gate_b, 8'h40);
        wr(3'd1, 8'h9F); rd(3'd1, d); chk("R9 gate_b pin after 9F", d, 8'hDF);
        wr(3'd2, 8'hFF); rd(3'd2, d);
        chk("R10 auto all ones", d, 8'h74); chk("R10 auto port", auto_gate, 8'h74);
        wr(3'd2, 8'h20); rd(3'd2, d); chk("R10 auto partial", d, 8'h20);
        wr(3'd7, 8'h0B); rd(3'd7, d); chk("R11 settle readback", d, 8'h0B);
    endtask

    task automatic t_stage;
        logic [7:0] d;
        wr(3'd3, 8'h03); rd(3'd3, d); chk("R2 staged legal", d, 8'h03);
        rd(3'd4, d); chk("R3 active unchanged", d, 8'h07);
        chk("R3 pll_code unchanged", pll_code, 4'h7);
        wr(3'd3, 8'h05); rd(3'd3, d); chk("R2 illegal 5 ignored", d, 8'h03);
        wr(3'd3, 8'h00); rd(3'd3, d); chk("R2 illegal 0 ignored", d, 8'h03);
        chk("R2 pll_code after illegal", pll_code, 4'h7);
    endtask

    task automatic t_commit_min;
        logic [7:0] d;
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h00);
        cs_n = 1'b0;
        run_sleep("R4 settle0 pad off", 0, 1, 4'h3);
        chk("R5 irq set", pll_irq, 1);
        rd(3'd5, d); chk("R5 status evt", d, 8'h01);
        rd(3'd4, d); chk("R4 active reg", d, 8'h03);
        cs_n = 1'b1;
    endtask

    task automatic t_commit_max;
        logic [7:0] d;
        wr(3'd7, 8'h0F);
        wr(3'd3, 8'h09);
        run_sleep("R6 settle15 irq held", 15, 1, 4'h9);
        wr(3'd5, 8'h00); rd(3'd5, d); chk("R6 write 0 keeps evt", d, 8'h01);
        wr(3'd5, 8'h01); rd(3'd5, d); chk("R6 W1C evt", d, 8'h00);
        chk("R6 irq cleared", pll_irq, 0);
    endtask

    task automatic t_blocked;
        logic [7:0] d;
        wr(3'd6, 8'h01);
        wr(3'd7, 8'h02);
        wr(3'd3, 8'h01);
        cs_n = 1'b0;
        run_sleep("R7 blocked", 2, 0, 4'h9);
        chk("R7 no irq", pll_irq, 0);
        rd(3'd5, d); chk("R7 fail flag", d, 8'h04);
        wr(3'd5, 8'h04); rd(3'd5, d); chk("R7 fail W1C", d, 8'h00);
        cs_n = 1'b1;
        run_sleep("R7 cs high proceeds", 2, 1, 4'h1);
        chk("R7 irq after proceed", pll_irq, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gating();
        t_stage();
        t_commit_min();
        t_commit_max();
        t_blocked();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule